// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the general-purpose register storage for a single-cycle RISC core. It holds 32 architectural registers of 32 bits each. Two operand read ports each take a register number and return that register's contents in the same cycle, with no clock edge in the path. A single write port stores a result at the rising clock edge when its enable is high.

The highest register number is a constant zero. Reads of it always return zero. Writes to it are dropped, so the block builds storage only for the other 31 registers. A read of a register that is being written in the same cycle sees the contents from before that write. The new value appears on the read port only after the edge, because the block has no forwarding path. An active-high synchronous reset clears all stored registers.

Top module: `regfile_2r1w`

## Requirements
- R1: A clock edge with `rst` high clears every stored register, so that after reset all 32 register numbers read as zero on both read ports.
- R2: When `wr_en` is high at a rising edge and `wr_addr` is in the range 0 to 30, that register takes `wr_data`, and both read ports return it from then on until it is written again.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: Register number 31 (all address bits set) reads as zero on either read port at all times, including right after a write addressed to it.
- R5: A write addressed to register 31 changes no other register.
- R6: If a read port addresses the register being written, it returns the old contents during the write cycle and the new contents in the cycle after the edge. No value is forwarded from `wr_data`.
- R7: The two read ports are independent. Different addresses presented at the same time each return their own register's contents.
- R8: Reset wins over a write in the same cycle. A write presented while `rst` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all stored registers |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the register selected by `rd_addr_a`, combinational |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the register selected by `rd_addr_b`, combinational |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Value to write |

## Verification
The sharpest corner is a read of the register being written. The bench samples both ports just before the edge and again just after it. A design with an accidental bypass would show the new value too early, and one that latched reads would show it too late. Register 31 is written with a nonzero pattern and then read on both ports, and every other register is compared afterwards. This catches a zero register that stores its writes, or whose write spills into a neighbour through a decoding error. A write with the enable low, and a write made during reset, must both leave the registers untouched. A design that ignored the enable or gave the write priority over reset would show the stray data on the read ports.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W = 32;
  localparam int RF_ADDR_W = 5;

  function automatic int rf_store_count(input int addr_w);
    return (1 << addr_w) - 1;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  output logic [rf_pkg::rf_store_count(ADDR_W)-1:0] row_en
);
  localparam int NUM_STORE = rf_pkg::rf_store_count(ADDR_W);

  // Rows exist only for 0 .. NUM_STORE-1; the all-ones number matches none.
  for (genvar i = 0; i < NUM_STORE; i++) begin : g_row
    assign row_en[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [rf_pkg::rf_store_count(ADDR_W)-1:0] row_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [rf_pkg::rf_store_count(ADDR_W)-1:0][DATA_W-1:0] rows
);
  localparam int NUM_STORE = rf_pkg::rf_store_count(ADDR_W);

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)            rows[i] <= '0;
      else if (row_en[i]) rows[i] <= wr_data;
    end

    // R2: an enabled row holds the written data after the edge
    a_r2_row_load: assert property (@(posedge clk) disable iff (rst)
      row_en[i] |=> rows[i] == $past(wr_data));

    // R3: a row without enable keeps its value
    a_r3_row_hold: assert property (@(posedge clk) disable iff (rst)
      !row_en[i] |=> $stable(rows[i]));
  end

  // R5: at most one row is written per edge
  a_r5_single_row: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en));

  // R1, R8: reset clears every row regardless of enables
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> rows == '0);
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [rf_pkg::rf_store_count(ADDR_W)-1:0][DATA_W-1:0] rows,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] ZERO_IDX = '1;

  always_comb begin
    rd_data = '0;
    if (rd_addr != ZERO_IDX) rd_data = rows[rd_addr];
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NUM_STORE = rf_pkg::rf_store_count(ADDR_W);
  localparam int NUM_RD    = 2;
  localparam logic [ADDR_W-1:0] ZERO_IDX = '1;

  logic [NUM_STORE-1:0]             row_en;
  logic [NUM_STORE-1:0][DATA_W-1:0] rows;
  logic [ADDR_W-1:0]                rd_addr_v [NUM_RD];
  logic [DATA_W-1:0]                rd_data_v [NUM_RD];

  rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .row_en  (row_en)
  );

  rf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .row_en  (row_en),
    .wr_data (wr_data),
    .rows    (rows)
  );

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .rd_addr (rd_addr_v[p]),
      .rows    (rows),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];

  // R4: the zero register reads zero on both ports
  a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
    rd_addr_a == ZERO_IDX |-> rd_data_a == '0);
  a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
    rd_addr_b == ZERO_IDX |-> rd_data_b == '0);

  // R5: a write to the zero register leaves all storage unchanged
  a_r5_zero_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ZERO_IDX) |=> $stable(rows));

  // R6: port A shows the new value one cycle after a same-address write
  a_r6_new_after_edge: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ZERO_IDX && rd_addr_a == wr_addr) ##1
    (rd_addr_a == $past(wr_addr)) |-> rd_data_a == $past(wr_data));
endmodule

// File: tb/regfile_2r1w_test.sv
module regfile_2r1w_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0;
  logic [4:0]  rd_addr_b = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;

  logic [31:0] model [32];
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  regfile_2r1w uut (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] pat(input int i);
    return {8'hC3, 8'(i), 8'(~i), 8'(i * 3 + 1)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 31) model[a] = d;
  endtask

  task automatic read_pair(input int a, input int b, input string tag);
    rd_addr_a = 5'(a); rd_addr_b = 5'(b);
    #0.5;
    check(tag, rd_data_a, model[a]);
    check(tag, rd_data_b, model[b]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      read_pair(i, 31 - i, tag);
    end
  endtask

  // R1: reset state
  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
    sweep("R1 reset state");
  endtask

  // R2, R7: fill and read with independent addresses
  task automatic t_fill();
    for (int i = 0; i < 31; i++) write_reg(i, pat(i));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      read_pair(i, (i + 7) % 32, "R2 R7 readback");
    end
  endtask

  // R3: enable low leaves contents alone
  task automatic t_hold();
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd3; wr_data = 32'hFFFF_0000;
    repeat (2) @(negedge clk);
    read_pair(3, 3, "R3 enable low");
    sweep("R3 enable low sweep");
  endtask

  // R4, R5: zero register
  task automatic t_zero();
    write_reg(31, 32'hDEAD_BEEF);
    @(negedge clk);
    read_pair(31, 31, "R4 zero register");
    check("R4 zero register literal", rd_data_a, 32'h0);
    sweep("R5 zero write isolated");
  endtask

  // R6: read during write, old then new, both ports
  task automatic t_rdw(input int a);
    logic [31:0] nv;
    nv = ~pat(a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = nv;
    rd_addr_a = 5'(a); rd_addr_b = 5'(a);
    #0.5;
    check("R6 old value port A", rd_data_a, model[a]);
    check("R6 old value port B", rd_data_b, model[a]);
    @(posedge clk);
    #0.5;
    check("R6 new value port A", rd_data_a, nv);
    check("R6 new value port B", rd_data_b, nv);
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = nv;
  endtask

  // R7: two different registers at once
  task automatic t_dual();
    @(negedge clk);
    read_pair(0, 30, "R7 independent ports");
    @(negedge clk);
    read_pair(17, 2, "R7 independent ports");
  endtask

  // R8, R1: reset beats a write in the same cycle
  task automatic t_reset_write();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd4; wr_data = 32'h1234_5678;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    clear_model();
    read_pair(4, 4, "R8 write during reset");
    sweep("R1 reset after writes");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clear_model();
    t_reset_state();
    t_fill();
    t_hold();
    t_zero();
    t_rdw(9);
    t_rdw(0);
    t_rdw(30);
    t_dual();
    t_reset_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule